// File: doc/BRIEF.md
# Registered ALU with Size-Aware Status Flags

This block is an arithmetic/logic unit that works on 8-bit, 16-bit or 32-bit operands. It performs addition, subtraction, AND, OR and XOR. With each result it produces six status flags: carry, overflow, sign, zero, half-carry (auxiliary carry) and parity. The result and the flags are captured in registers one clock after a valid strobe, so the unit fits in a single pipeline stage of a larger execution datapath.

The operand-size select decides which bit is the sign bit and the carry-out position. Operand bits above the selected size are ignored. Result bits above the selected size read as zero. The flags are therefore always evaluated at the width the instruction asked for. Subtraction reports borrows in the carry and half-carry flags. Logical operations report no carry, no overflow and no half-carry.

Top module: `alu_status_top`

## Requirements
- R1: The result is computed only over the selected size. The size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, and 3 = 32-bit as well. Operand bits above the size are ignored, and result bits above it are 0. The opcodes are 0 = add, 1 = subtract (A minus B), 2 = AND, 3 = OR, 4 = XOR. The flag vector bits, from bit 0 to bit 5, are: carry, parity, auxiliary carry, zero, sign, overflow.
- R2: For add, carry is 1 when the unsigned sum does not fit in the selected size. For subtract, carry is 1 when A is below B as unsigned numbers (a borrow).
- R3: For add and subtract, overflow is 1 when the true signed result lies outside the signed range of the selected size.
- R4: Sign equals the result bit at the top of the selected size: bit 7, 15 or 31.
- R5: Zero is 1 exactly when every result bit within the selected size is 0.
- R6: Auxiliary carry is 1 when add carries out of bit 3 into bit 4, or when subtract borrows into bit 3 from bit 4.
- R7: Parity is 1 when the low 8 bits of the result hold an even number of ones, whatever the size.
- R8: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R9: The result, flags and out_valid appear on the clock edge after in_valid is sampled high. out_valid is low after an edge where in_valid was low, and the result and flags then keep their previous values.
- R10: While reset is high, out_valid, the result and all flags are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode (add, sub, and, or, xor) |
| in_size | input | 2 | Operand size select |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flags updated this cycle |
| out_result | output | 32 | Registered result, zero above the selected size |
| out_flags | output | 6 | Registered status flags |

## Verification
The assertions assume that in_op carries only the five defined opcodes whenever in_valid is high. Codes 5 to 7 have no defined flags, so properties tied to the operation class would not hold for them. The stimulus table and the directed tests drive only codes 0 to 4. They also exercise size code 3, which must behave exactly like 32-bit. Operands carry nonzero bits above the selected size, so that ignoring those bits is actually observed.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PAR_W   = 8;
    localparam int unsigned NIB_BIT = 4;
    localparam int unsigned OP_W    = 3;
    localparam int unsigned SIZE_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } opsize_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } status_t;

    localparam int unsigned FLAG_W = $bits(status_t);

    function automatic int unsigned top_bit(opsize_e s);
        case (s)
            SZ_BYTE: top_bit = 7;
            SZ_HALF: top_bit = 15;
            default: top_bit = WORD_W - 1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(opsize_e s);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i <= int'(top_bit(s)));
        end
        return m;
    endfunction

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_status_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              do_sub,
    input  opsize_e           size,
    output logic [WORD_W-1:0] res,
    output logic              cry,
    output logic              ovf,
    output logic              aux
);
    logic [WORD_W:0]   ext;
    logic [WORD_W-1:0] mask;
    logic [WORD_W:0]   mix;
    int unsigned       tb;
    logic              sa, sb, sr;

    always_comb begin
        tb   = top_bit(size);
        mask = size_mask(size);
        ext  = do_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        res  = ext[WORD_W-1:0] & mask;
        // operands are masked, so the bit just above the size is carry/borrow
        cry  = ext[tb + 1];
        mix  = {1'b0, a ^ b} ^ ext;
        aux  = mix[NIB_BIT];
        sa   = a[tb];
        sb   = b[tb];
        sr   = res[tb];
        if (do_sub) ovf = (sa != sb) && (sr != sa);
        else        ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_status_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  alu_op_e           op,
    output logic [WORD_W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            default: res = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_status_pkg::*;
(
    input  logic [WORD_W-1:0] res,
    input  opsize_e           size,
    output logic              sgn,
    output logic              zro,
    output logic              par
);
    always_comb begin
        sgn = res[top_bit(size)];
        zro = ((res & size_mask(size)) == '0);
        par = ~^res[PAR_W-1:0];
    end
endmodule

// File: rtl/alu_status_top.sv
module alu_status_top
    import alu_status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      in_op,
    input  logic [SIZE_W-1:0]    in_size,
    input  logic [WORD_W-1:0]    in_a,
    input  logic [WORD_W-1:0]    in_b,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_result,
    output logic [FLAG_W-1:0]    out_flags
);
    alu_op_e           op;
    opsize_e           size;
    logic [WORD_W-1:0] a_m, b_m;
    logic [WORD_W-1:0] arith_res, logic_res, sel_res;
    logic              a_cry, a_ovf, a_aux;
    logic              f_sgn, f_zro, f_par;
    logic              logic_sel;
    status_t           next_flags, flags_q;
    logic [WORD_W-1:0] result_q;
    logic              valid_q;

    always_comb begin
        op        = alu_op_e'(in_op);
        size      = opsize_e'(in_size);
        a_m       = in_a & size_mask(size);
        b_m       = in_b & size_mask(size);
        logic_sel = is_logic_op(op);
    end

    alu_arith_unit u_arith (
        .a      (a_m),
        .b      (b_m),
        .do_sub (op == OP_SUB),
        .size   (size),
        .res    (arith_res),
        .cry    (a_cry),
        .ovf    (a_ovf),
        .aux    (a_aux)
    );

    alu_logic_unit u_logic (
        .a   (a_m),
        .b   (b_m),
        .op  (op),
        .res (logic_res)
    );

    assign sel_res = logic_sel ? logic_res : arith_res;

    alu_flag_gen u_flags (
        .res  (sel_res),
        .size (size),
        .sgn  (f_sgn),
        .zro  (f_zro),
        .par  (f_par)
    );

    always_comb begin
        next_flags.cry = logic_sel ? 1'b0 : a_cry;
        next_flags.ovf = logic_sel ? 1'b0 : a_ovf;
        next_flags.aux = logic_sel ? 1'b0 : a_aux;
        next_flags.sgn = f_sgn;
        next_flags.zro = f_zro;
        next_flags.par = f_par;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= sel_res;
                flags_q  <= next_flags;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_result = result_q;
    assign out_flags  = flags_q;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid && out_flags == '0); // R10
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid && $stable(out_result)); // R9
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_logic_op(alu_op_e'(in_op)) |=> !flags_q.cry && !flags_q.ovf && !flags_q.aux); // R8
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst) out_valid |-> flags_q.zro == (out_result == '0)); // R5
    AST_PARITY_LOW: assert property (@(posedge clk) disable iff (rst) out_valid |-> flags_q.par == ~^out_result[PAR_W-1:0]); // R7
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_size == SZ_BYTE |=> out_result[WORD_W-1:PAR_W] == '0); // R1
    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == OP_ADD && in_size == SZ_WORD |=> flags_q.cry == (out_result < $past(in_a))); // R2
endmodule

// File: tb/test_alu_status_top.sv
`timescale 1ns/1ps
module test_alu_status_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [1:0]  in_size;
    logic [31:0] in_a, in_b;
    logic        out_valid;
    logic [31:0] out_result;
    logic [5:0]  out_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alu_status_top i_alu_status_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [5:0]  f;   // {ovf, sgn, zro, aux, par, cry}
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 6'b110100},
        '{3'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000000, 6'b001111},
        '{3'd0, 2'd1, 32'h00008000, 32'h00008000, 32'h00000000, 6'b101011},
        '{3'd0, 2'd2, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 6'b000101},
        '{3'd1, 2'd0, 32'h00000000, 32'h00000001, 32'h000000FF, 6'b010111},
        '{3'd1, 2'd0, 32'h00000080, 32'h00000001, 32'h0000007F, 6'b100100},
        '{3'd1, 2'd1, 32'h00001234, 32'h00001234, 32'h00000000, 6'b001010},
        '{3'd1, 2'd2, 32'h00000010, 32'h00000001, 32'h0000000F, 6'b000110},
        '{3'd2, 2'd0, 32'h000000F0, 32'h0000003C, 32'h00000030, 6'b000010},
        '{3'd3, 2'd1, 32'h00008000, 32'h00000001, 32'h00008001, 6'b010000},
        '{3'd4, 2'd2, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 6'b001010},
        '{3'd0, 2'd0, 32'h12345601, 32'hABCDEF02, 32'h00000003, 6'b000010},
        '{3'd4, 2'd0, 32'hFFFFFFFF, 32'h00000000, 32'h000000FF, 6'b010010},
        '{3'd1, 2'd2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 6'b100110},
        '{3'd0, 2'd1, 32'h000000FF, 32'h00000001, 32'h00000100, 6'b000110},
        '{3'd2, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'b010010}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input int idx);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s case %0d: actual %h expected %h", tag, idx, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_flags(input logic [2:0] op, input logic [5:0] exp, input int idx);
        bit lg = (op >= 3'd2);
        check(lg ? "R8 carry" : "R2 carry", {31'd0, out_flags[0]}, {31'd0, exp[0]}, idx);
        check("R7 parity", {31'd0, out_flags[1]}, {31'd0, exp[1]}, idx);
        check(lg ? "R8 aux" : "R6 aux", {31'd0, out_flags[2]}, {31'd0, exp[2]}, idx);
        check("R5 zero", {31'd0, out_flags[3]}, {31'd0, exp[3]}, idx);
        check("R4 sign", {31'd0, out_flags[4]}, {31'd0, exp[4]}, idx);
        check(lg ? "R8 overflow" : "R3 overflow", {31'd0, out_flags[5]}, {31'd0, exp[5]}, idx);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_size = '0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {31'd0, out_valid}, 32'd0, -1);
        check("R10 reset result", out_result, 32'd0, -1);
        check("R10 reset flags", {26'd0, out_flags}, 32'd0, -1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b);
            check("R9 valid", {31'd0, out_valid}, 32'd1, i);
            check("R1 result", out_result, VECS[i].r, i);
            check_flags(VECS[i].op, VECS[i].f, i);
        end

        // R9: no strobe, new inputs, outputs hold and valid drops
        @(negedge clk);
        in_op = 3'd0; in_size = 2'd2; in_a = 32'h11111111; in_b = 32'h22222222;
        @(negedge clk);
        check("R9 valid low", {31'd0, out_valid}, 32'd0, 100);
        check("R9 hold result", out_result, 32'hFFFFFFFF, 100);
        check("R9 hold flags", {26'd0, out_flags}, {26'd0, 6'b010010}, 100);

        // R1: size code 3 behaves as 32-bit
        issue(3'd0, 2'd3, 32'hFFFFFFFF, 32'h00000001);
        check("R1 wide size result", out_result, 32'h00000000, 101);
        check_flags(3'd0, 6'b001111, 101);

        // R10: reset mid-stream clears captured state
        issue(3'd3, 2'd2, 32'hF0F0F0F0, 32'h0F0F0F0F);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset result", out_result, 32'd0, 102);
        check("R10 reset flags", {26'd0, out_flags}, 32'd0, 102);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule